// File: doc/BRIEF.md
# BCD Time and Calendar Entry Checker

This block sits between a host write path and the time, calendar and alarm registers of a real-time clock. It checks each 32-bit word the host writes before that word may load. The host presents the word, a 2-bit code naming the target register, and the current 12/24-hour mode, with `wr_valid` high for one cycle. The checker then decides whether every field of the word is legal BCD within its range, including the cross-field rules. These rules cover the month length against the date, leap years, and the hour range against the mode and the PM bit.

The control is a two-state machine. `ST_IDLE` waits for a write. The transition `T_CAPTURE` (taken on `wr_valid` from either state) registers the word, target and mode and enters `ST_CHECK`. In `ST_CHECK` the judgement is shown. The transition `T_RELEASE` (no new write) returns to `ST_IDLE`. The transition `T_CHAIN` (a new write arrives) stays in `ST_CHECK` with the new word. While in `ST_CHECK`, an accepted word pulses one load-enable bit. The result also updates a sticky invalid flag for that target. A rejected word sets the flag, and only a later accepted word to the same target clears it. There is no software clear.

Target codes: 0 time, 1 calendar, 2 time alarm, 3 calendar alarm. Load-enable and invalid-flag bit i belong to target code i.

Top module: `rtc_entry_checker`

## Requirements
- R1: After reset, `inv_flags` is 0000 and `load_en` is 0000.
- R2: Time word: seconds in bits 6:0 and minutes in bits 14:8. Each must have both BCD nibbles at or below 9 and a value of 00–59, otherwise the word is rejected.
- R3: In 24-hour mode (`hour12`=0), the hour in bits 21:16 must be 00–23 and the PM bit (bit 22) must be clear.
- R4: In 12-hour mode (`hour12`=1), the hour must be 01–12, with PM (bit 22) either value.
- R5: Calendar word: century in bits 7:0 must be 19 or 20. Year in bits 15:8 must be legal BCD (00–99).
- R6: Calendar month in bits 20:16 must be 01–12. Day-of-week in bits 23:21 must be 1–7. Date in bits 29:24 must be 01–31.
- R7: The calendar date must not exceed the month length. April, June, September and November have 30 days. February has 29 days when the binary value of the candidate year is a multiple of 4, and 28 otherwise.
- R8: Alarm words are checked only on fields whose enable bit is set, and only for range. The time alarm uses the time layout with enables at bits 7, 15 and 23, and the hour follows R3/R4. The calendar alarm has month in bits 20:16 (enable 23) and date in bits 29:24 (enable 31). An alarm date of 31 is allowed in any month.
- R9: An accepted word raises `load_en[target]` alone, for one cycle, in the cycle after the capturing edge. One edge later, `inv_flags[target]` reads 0.
- R10: A rejected word raises no load-enable bit. It sets `inv_flags[target]` one edge after the check cycle, and the flag stays set across later writes to other targets. The flags of the other targets are unchanged.
- R11: Invalid flags change only at the end of a check cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_target | input | 2 | Target register code |
| wr_word | input | 32 | Candidate word |
| hour12 | input | 1 | 1 = 12-hour mode |
| load_en | output | 4 | One-hot load pulse per target |
| inv_flags | output | 4 | Sticky invalid flag per target |

## Verification
A word driven with `wr_valid` is captured at edge k. Its `load_en` judgement is valid between edges k and k+1. The flag update becomes visible after edge k+1. The bench drives on falling edges. It samples `load_en` on the falling edge that follows the capture, and samples `inv_flags` one falling edge later. A bench model of all four flags is compared as a whole after every write, so an unintended change to another target's flag is also caught.

// File: rtl/rtc_entry_pkg.sv
package rtc_entry_pkg;
    localparam int WORD_W = 32;
    localparam int NREG   = 4;
    localparam int TGT_W  = $clog2(NREG);

    localparam logic [TGT_W-1:0] TGT_TIME  = 2'd0;
    localparam logic [TGT_W-1:0] TGT_CAL   = 2'd1;
    localparam logic [TGT_W-1:0] TGT_TALRM = 2'd2;
    localparam logic [TGT_W-1:0] TGT_CALRM = 2'd3;

    typedef enum logic {ST_IDLE, ST_CHECK} chk_state_t;

    function automatic logic bcd_ok(input logic [7:0] b);
        return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
    endfunction

    function automatic logic [6:0] bcd_val(input logic [7:0] b);
        return ({3'b0, b[7:4]} * 7'd10) + {3'b0, b[3:0]};
    endfunction

    function automatic logic bcd_in(input logic [7:0] b, input logic [6:0] lo,
                                    input logic [6:0] hi);
        return bcd_ok(b) && (bcd_val(b) >= lo) && (bcd_val(b) <= hi);
    endfunction

    function automatic logic [6:0] month_len(input logic [6:0] m, input logic leap);
        case (m)
            7'd2:                   return leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
            default:                return 7'd31;
        endcase
    endfunction
endpackage

// File: rtl/entry_time_chk.sv
module entry_time_chk
    import rtc_entry_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              hour12,
    input  logic              is_alarm,
    output logic              ok
);
    logic [7:0] sec_b, min_b, hr_b;
    logic       pm, sec_ok, min_ok, hr_ok;

    always_comb begin
        sec_b  = {1'b0, word[6:0]};
        min_b  = {1'b0, word[14:8]};
        hr_b   = {2'b0, word[21:16]};
        pm     = word[22];
        sec_ok = bcd_in(sec_b, 7'd0, 7'd59) || (is_alarm && !word[7]);
        min_ok = bcd_in(min_b, 7'd0, 7'd59) || (is_alarm && !word[15]);
        if (hour12)
            hr_ok = bcd_in(hr_b, 7'd1, 7'd12);
        else
            hr_ok = bcd_in(hr_b, 7'd0, 7'd23) && !pm;
        hr_ok = hr_ok || (is_alarm && !word[23]);
        ok    = sec_ok && min_ok && hr_ok;
    end
endmodule

// File: rtl/entry_cal_chk.sv
module entry_cal_chk
    import rtc_entry_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              is_alarm,
    output logic              ok
);
    logic [7:0] cent_b, year_b, mon_b, date_b;
    logic [2:0] dow;
    logic       leap, mon_ok, date_ok, cal_ok, alm_ok;

    always_comb begin
        cent_b  = word[7:0];
        year_b  = word[15:8];
        mon_b   = {3'b0, word[20:16]};
        dow     = word[23:21];
        date_b  = {2'b0, word[29:24]};
        leap    = (bcd_val(year_b) % 7'd4) == 7'd0;
        mon_ok  = bcd_in(mon_b, 7'd1, 7'd12);
        date_ok = bcd_in(date_b, 7'd1, 7'd31);
        cal_ok  = ((cent_b == 8'h19) || (cent_b == 8'h20)) && bcd_ok(year_b)
                  && mon_ok && date_ok && (dow != 3'd0)
                  && (bcd_val(date_b) <= month_len(bcd_val(mon_b), leap));
        alm_ok  = (mon_ok || !word[23]) && (date_ok || !word[31]);
        ok      = is_alarm ? alm_ok : cal_ok;
    end
endmodule

// File: rtl/entry_flag_bank.sv
module entry_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [N-1:0] sel,
    input  logic         ok,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (strobe && sel[i])
                flags[i] <= !ok;
        end
    end
endmodule

// File: rtl/rtc_entry_checker.sv
module rtc_entry_checker
    import rtc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [TGT_W-1:0]  wr_target,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              hour12,
    output logic [NREG-1:0]   load_en,
    output logic [NREG-1:0]   inv_flags
);
    chk_state_t        state, state_nx;
    logic [WORD_W-1:0] word_q;
    logic [TGT_W-1:0]  tgt_q;
    logic              h12_q, time_ok, cal_ok, word_ok, busy;
    logic [NREG-1:0]   sel;

    always_comb begin
        unique case (state)
            ST_IDLE:  state_nx = wr_valid ? ST_CHECK : ST_IDLE;
            ST_CHECK: state_nx = wr_valid ? ST_CHECK : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            tgt_q  <= '0;
            h12_q  <= 1'b0;
        end else if (wr_valid) begin
            word_q <= wr_word;
            tgt_q  <= wr_target;
            h12_q  <= hour12;
        end
    end

    entry_time_chk u_time (
        .word(word_q), .hour12(h12_q), .is_alarm(tgt_q == TGT_TALRM), .ok(time_ok)
    );
    entry_cal_chk u_cal (
        .word(word_q), .is_alarm(tgt_q == TGT_CALRM), .ok(cal_ok)
    );

    always_comb begin
        busy    = 1'b0;
        sel     = '0;
        load_en = '0;
        word_ok = ((tgt_q == TGT_TIME) || (tgt_q == TGT_TALRM)) ? time_ok : cal_ok;
        unique case (state)
            ST_IDLE: ;
            ST_CHECK: begin
                busy       = 1'b1;
                sel[tgt_q] = 1'b1;
                load_en    = word_ok ? sel : '0;
            end
            default: ;
        endcase
    end

    entry_flag_bank #(.N(NREG)) u_flags (
        .clk(clk), .rst_n(rst_n), .strobe(busy), .sel(sel), .ok(word_ok), .flags(inv_flags)
    );
endmodule

module entry_chk_sva #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_valid,
    input logic         busy,
    input logic [N-1:0] load_en,
    input logic [N-1:0] inv_flags
);
    // R9
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_en));
    // R9
    load_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_en) |=> ((inv_flags & $past(load_en)) == '0));
    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(inv_flags));
    // R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> busy);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (load_en == '0));
endmodule

bind rtc_entry_checker entry_chk_sva #(.N(rtc_entry_pkg::NREG)) u_sva (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .busy(busy),
    .load_en(load_en), .inv_flags(inv_flags)
);

// File: tb/sim_rtc_entry_checker.sv
module sim_rtc_entry_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_target = '0;
    logic [31:0] wr_word = '0;
    logic        hour12 = 1'b0;
    logic [3:0]  load_en, inv_flags;
    logic [3:0]  exp_flags = '0;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rtc_entry_checker u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_target(wr_target),
        .wr_word(wr_word), .hour12(hour12), .load_en(load_en), .inv_flags(inv_flags)
    );

    function automatic logic [31:0] tm(input logic [7:0] hr, input logic pm,
                                       input logic [7:0] mn, input logic [7:0] sc);
        return {9'b0, pm, hr[5:0], 1'b0, mn[6:0], 1'b0, sc[6:0]};
    endfunction

    function automatic logic [31:0] cal(input logic [7:0] dt, input logic [2:0] dw,
                                        input logic [7:0] mo, input logic [7:0] yr,
                                        input logic [7:0] ce);
        return {2'b0, dt[5:0], dw, mo[4:0], yr, ce};
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_write(input string req, input logic [1:0] tgt, input logic [31:0] w,
                            input logic h12, input logic good);
        @(negedge clk);
        wr_valid = 1'b1; wr_target = tgt; wr_word = w; hour12 = h12;
        @(negedge clk);
        wr_valid = 1'b0;
        chk({req, " load"}, load_en, good ? (4'b1 << tgt) : 4'b0);
        exp_flags[tgt] = !good;
        @(negedge clk);
        chk({req, " flags"}, inv_flags, exp_flags);
        chk({req, " load done"}, load_en, 4'b0);
    endtask

    task automatic t_reset();
        chk("R1 flags", inv_flags, 4'b0);
        chk("R1 load", load_en, 4'b0);
    endtask

    task automatic t_time_24();
        do_write("R2 max time", 2'd0, tm(8'h23, 1'b0, 8'h59, 8'h59), 1'b0, 1'b1);
        do_write("R2 sec nibble A", 2'd0, tm(8'h10, 1'b0, 8'h00, 8'h5A), 1'b0, 1'b0);
        do_write("R2 sec 60", 2'd0, tm(8'h10, 1'b0, 8'h00, 8'h60), 1'b0, 1'b0);
        do_write("R2 min 60", 2'd0, tm(8'h10, 1'b0, 8'h60, 8'h00), 1'b0, 1'b0);
        do_write("R3 hour 24", 2'd0, tm(8'h24, 1'b0, 8'h00, 8'h00), 1'b0, 1'b0);
        do_write("R3 pm in 24h", 2'd0, tm(8'h00, 1'b1, 8'h00, 8'h00), 1'b0, 1'b0);
        do_write("R3 hour 00", 2'd0, tm(8'h00, 1'b0, 8'h00, 8'h00), 1'b0, 1'b1);
    endtask

    task automatic t_time_12();
        do_write("R4 12 pm", 2'd0, tm(8'h12, 1'b1, 8'h10, 8'h30), 1'b1, 1'b1);
        do_write("R4 hour 00", 2'd0, tm(8'h00, 1'b0, 8'h00, 8'h00), 1'b1, 1'b0);
        do_write("R4 hour 13", 2'd0, tm(8'h13, 1'b0, 8'h00, 8'h00), 1'b1, 1'b0);
        do_write("R4 hour 01 am", 2'd0, tm(8'h01, 1'b0, 8'h00, 8'h00), 1'b1, 1'b1);
    endtask

    task automatic t_calendar();
        do_write("R5 century 21", 2'd1, cal(8'h01, 3'd1, 8'h01, 8'h00, 8'h21), 1'b0, 1'b0);
        // R10: calendar flag stays set while a time word is accepted
        do_write("R10 other target", 2'd0, tm(8'h05, 1'b0, 8'h00, 8'h00), 1'b0, 1'b1);
        do_write("R5 year nibble", 2'd1, cal(8'h01, 3'd1, 8'h01, 8'h9A, 8'h19), 1'b0, 1'b0);
        do_write("R5 good 1999", 2'd1, cal(8'h31, 3'd5, 8'h12, 8'h99, 8'h19), 1'b0, 1'b1);
        do_write("R6 month 13", 2'd1, cal(8'h01, 3'd1, 8'h13, 8'h10, 8'h20), 1'b0, 1'b0);
        do_write("R6 day 0", 2'd1, cal(8'h01, 3'd0, 8'h01, 8'h10, 8'h20), 1'b0, 1'b0);
        do_write("R6 date 00", 2'd1, cal(8'h00, 3'd1, 8'h01, 8'h10, 8'h20), 1'b0, 1'b0);
        do_write("R7 Apr 31", 2'd1, cal(8'h31, 3'd1, 8'h04, 8'h10, 8'h20), 1'b0, 1'b0);
        do_write("R7 Apr 30", 2'd1, cal(8'h30, 3'd1, 8'h04, 8'h10, 8'h20), 1'b0, 1'b1);
        do_write("R7 Feb 29 2023", 2'd1, cal(8'h29, 3'd3, 8'h02, 8'h23, 8'h20), 1'b0, 1'b0);
        do_write("R7 Feb 29 2024", 2'd1, cal(8'h29, 3'd4, 8'h02, 8'h24, 8'h20), 1'b0, 1'b1);
        do_write("R7 Feb 29 2000", 2'd1, cal(8'h29, 3'd2, 8'h02, 8'h00, 8'h20), 1'b0, 1'b1);
        do_write("R7 Feb 30", 2'd1, cal(8'h30, 3'd2, 8'h02, 8'h24, 8'h20), 1'b0, 1'b0);
    endtask

    task automatic t_alarms();
        do_write("R8 talarm disabled junk", 2'd2, 32'h007F_7F7F & ~32'h0080_8080, 1'b0, 1'b1);
        do_write("R8 talarm sec 60", 2'd2, tm(8'h00, 1'b0, 8'h00, 8'h60) | 32'h80, 1'b0, 1'b0);
        do_write("R8 talarm 12h hour 00", 2'd2, tm(8'h00, 1'b0, 8'h00, 8'h00) | 32'h0080_0000,
                 1'b1, 1'b0);
        do_write("R8 talarm ok", 2'd2, tm(8'h07, 1'b0, 8'h15, 8'h30) | 32'h0080_8080, 1'b0, 1'b1);
        do_write("R8 calarm Feb 31", 2'd3, 32'h8000_0000 | (32'h31 << 24) | 32'h0080_0000
                 | (32'h02 << 16), 1'b0, 1'b1);
        do_write("R8 calarm month 13", 2'd3, 32'h0080_0000 | (32'h13 << 16), 1'b0, 1'b0);
        do_write("R8 calarm month off", 2'd3, (32'h13 << 16), 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_time_24();
        t_time_12();
        t_calendar();
        t_alarms();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%b expected=%b", 1'b0, 1'b1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule